// File: doc/BRIEF.md
# Debug Port JTAG Scan Controller

This block connects a JTAG scan chain to the register file of a debug port. It contains the complete sixteen-state test access port machine. That machine is clocked by the test clock and steered by the mode-select pin. A 4-bit instruction register picks which data register sits between the serial input and the serial output. The selectable registers are a 32-bit identification word, a 1-bit bypass stage, an abort word and a shared 35-bit access register. The access register serves both the debug-port and the access-port instructions.

An access scan carries a 2-bit register index, a read/write flag and a 32-bit word. When the machine passes through Update-DR, the block presents these fields to the register file as a one-cycle request. The request is tagged with the port it targets. The register file answers in the same cycle with an acknowledge code and a read word, and the block holds that answer. The next access scan captures the held answer and shifts it out, so the result of each access is returned one scan later. An abort scan gives a separate one-cycle strobe carrying its 32-bit word.

The reset input `trst_n` is active low and sampled on the rising test clock. The serial output is combinational and changes only after rising edges. The bench therefore drives and samples on falling edges.

Top module: `dbg_jtag_tap`

## Requirements
- R1: While `trst_n` is low at a rising edge, the machine goes to Test-Logic-Reset and the instruction becomes the identification code 4'hE. A data scan after reset returns `IDCODE_VAL`, least significant bit first.
- R2: Five consecutive rising edges with `tms` high bring the machine to Test-Logic-Reset from any state, with the same instruction reload as R1.
- R3: State transitions follow the standard sixteen-state graph, including the Exit1/Pause/Exit2 detour. Shifting resumes after that detour with no bit lost or repeated.
- R4: Capture-IR loads 4'b0001, so the first four bits shifted out of an instruction scan are 1, 0, 0, 0.
- R5: The instruction codes are 4'h8 abort, 4'hA debug-port access, 4'hB access-port access, 4'hE identification and 4'hF bypass. Every other code selects bypass, a one-bit stage that captures 0 and delays `tdi` by one bit.
- R6: The identification register is 32 bits long. Bit k of `IDCODE_VAL` appears on `tdo` in the k-th shift cycle.
- R7: In Update-DR with code 4'hA or 4'hB, `req_valid` is high for exactly that one cycle. Scan bit 0 drives `req_rnw` (1 = read), bits 2:1 drive `req_addr`, and bits 34:3 drive `req_wdata`. `req_ap` is 1 for 4'hB and 0 for 4'hA.
- R8: The `rsp_ack`/`rsp_rdata` values present while `req_valid` is high are held. The next access scan captures them, with the acknowledge in bits 2:0 and the read word in bits 34:3. After reset the held value is acknowledge 3'b010 (accepted) and read word 0.
- R9: In Update-DR with code 4'h8, `abort_valid` is high for one cycle with `abort_data` equal to scan bits 34:3, and no access request is made. An abort scan captures all zeros and leaves the held response unchanged.
- R10: `tdo` is 0 in every state other than Shift-DR and Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, sampled on rising `tck` |
| tms | input | 1 | Mode select steering the state machine |
| tdi | input | 1 | Serial data into the selected register |
| tdo | output | 1 | Serial data out of the selected register |
| req_valid | output | 1 | One-cycle access request strobe |
| req_ap | output | 1 | 1 = access port target, 0 = debug port target |
| req_addr | output | 2 | Register index within the selected port |
| req_rnw | output | 1 | 1 = read, 0 = write |
| req_wdata | output | DATA_W | Write word of the access |
| rsp_ack | input | 3 | Acknowledge code returned for the request |
| rsp_rdata | input | DATA_W | Read word returned for the request |
| abort_valid | output | 1 | One-cycle abort strobe |
| abort_data | output | DATA_W | Word shifted in by the abort scan |

## Verification
The bench builds the block with the default 32-bit data width. It overrides `IDCODE_VAL` with an irregular pattern, so that a wrong bit order or a shifted identification word shows up at once. With the 35-bit access scan at full width, random words reach every field boundary. This covers the index/flag split at bits 2:1 and bit 0, and the acknowledge placement. The bench also drives acknowledge codes other than 3'b010, so that the one-scan delay of R8 is checked with responses that differ from one access to the next.

// File: rtl/dbg_tap_pkg.sv
// Shared types for the debug JTAG controller: the state encoding,
// the instruction codes and the data-register selection.
package dbg_tap_pkg;

    localparam int IR_W   = 4;
    localparam int ADDR_W = 2;
    localparam int ACK_W  = 3;

    localparam logic [IR_W-1:0]  IR_ABORT  = 4'h8;
    localparam logic [IR_W-1:0]  IR_DPACC  = 4'hA;
    localparam logic [IR_W-1:0]  IR_APACC  = 4'hB;
    localparam logic [IR_W-1:0]  IR_IDCODE = 4'hE;
    localparam logic [IR_W-1:0]  IR_BYPASS = 4'hF;
    localparam logic [IR_W-1:0]  IR_CAPTURE = 4'b0001;
    localparam logic [ACK_W-1:0] ACK_OK    = 3'b010;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS, DR_IDCODE, DR_ACCESS, DR_ABORT
    } dr_sel_e;

endpackage

// File: rtl/dbg_tap_fsm.sv
// Sixteen-state test access port machine.
// Assumes: trst_n is sampled synchronously on rising tck.
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);
    tap_state_e nxt;

    // Next-state decode of the standard state graph.
    always_comb begin
        unique case (state)
            ST_TLR:      nxt = tms ? ST_TLR      : ST_RTI;
            ST_RTI:      nxt = tms ? ST_SEL_DR   : ST_RTI;
            ST_SEL_DR:   nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: nxt = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   nxt = tms ? ST_SEL_DR   : ST_RTI;
            ST_SEL_IR:   nxt = tms ? ST_TLR      : ST_CAP_IR;
            ST_CAP_IR:   nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: nxt = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   nxt = tms ? ST_SEL_DR   : ST_RTI;
            default:     nxt = ST_TLR;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end
endmodule

// File: rtl/dbg_tap_ir.sv
// Instruction shift and hold registers plus decode to a data-register
// selection. Assumes: the state input comes from dbg_tap_fsm.
module dbg_tap_ir
    import dbg_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_sr,
    output logic [IR_W-1:0] ir,
    output dr_sel_e         dr_sel,
    output logic            acc_ap
);
    // Shift register: capture pattern, shift LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_sr <= '0;
        else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
        else if (state == ST_SHIFT_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Hold register: reload identification code in reset, latch on update.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_TLR) ir <= IR_IDCODE;
        else if (state == ST_UPD_IR)    ir <= ir_sr;
    end

    // Decode; unknown codes fall back to bypass.
    always_comb begin
        acc_ap = 1'b0;
        unique case (ir)
            IR_DPACC:  dr_sel = DR_ACCESS;
            IR_APACC:  begin dr_sel = DR_ACCESS; acc_ap = 1'b1; end
            IR_ABORT:  dr_sel = DR_ABORT;
            IR_IDCODE: dr_sel = DR_IDCODE;
            default:   dr_sel = DR_BYPASS;
        endcase
    end
endmodule

// File: rtl/dbg_tap_dr.sv
// Data registers sharing one shift chain, plus the held response of the
// last access. Assumes: the register file answers in the request cycle.
module dbg_tap_dr
    import dbg_tap_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter logic [31:0] IDCODE_VAL = 32'h0000_0001
) (
    input  logic              tck,
    input  logic              trst_n,
    input  tap_state_e        state,
    input  dr_sel_e           dr_sel,
    input  logic              tdi,
    output logic              dr_tdo,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_rnw,
    output logic [DATA_W-1:0] req_wdata,
    input  logic [ACK_W-1:0]  rsp_ack,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              abort_valid,
    output logic [DATA_W-1:0] abort_data
);
    localparam int ACC_W  = DATA_W + ADDR_W + 1;
    localparam int HDR_W  = ADDR_W + 1;
    localparam int ID_PAD = ACC_W - 32;

    logic [ACC_W-1:0]  sr;
    logic [ACK_W-1:0]  ack_q;
    logic [DATA_W-1:0] rdata_q;

    // Shift chain: capture by selection, then shift with the length of the selection.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            sr <= '0;
        end else if (state == ST_CAP_DR) begin
            unique case (dr_sel)
                DR_ACCESS: sr <= {rdata_q, ack_q};
                DR_IDCODE: sr <= {{ID_PAD{1'b0}}, IDCODE_VAL};
                default:   sr <= '0;
            endcase
        end else if (state == ST_SHIFT_DR) begin
            unique case (dr_sel)
                DR_ACCESS, DR_ABORT: sr <= {tdi, sr[ACC_W-1:1]};
                DR_IDCODE: sr <= {sr[ACC_W-1:32], tdi, sr[31:1]};
                default:   sr <= {sr[ACC_W-1:1], tdi};
            endcase
        end
    end

    assign dr_tdo = sr[0];

    // Request fields come straight from the chain during Update-DR.
    assign req_valid   = (state == ST_UPD_DR) && (dr_sel == DR_ACCESS);
    assign req_rnw     = sr[0];
    assign req_addr    = sr[HDR_W-1:1];
    assign req_wdata   = sr[ACC_W-1:HDR_W];
    assign abort_valid = (state == ST_UPD_DR) && (dr_sel == DR_ABORT);
    assign abort_data  = sr[ACC_W-1:HDR_W];

    // Posted response: held until the next access capture.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            ack_q   <= ACK_OK;
            rdata_q <= '0;
        end else if (req_valid) begin
            ack_q   <= rsp_ack;
            rdata_q <= rsp_rdata;
        end
    end
endmodule

// File: rtl/dbg_jtag_tap.sv
// Top of the debug JTAG controller: state machine, instruction path,
// data path and the serial output multiplexer.
// Assumes: one tck domain, register file responds combinationally.
module dbg_jtag_tap
    import dbg_tap_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter logic [31:0] IDCODE_VAL = 32'h1BA5_E0C3
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              req_valid,
    output logic              req_ap,
    output logic [1:0]        req_addr,
    output logic              req_rnw,
    output logic [DATA_W-1:0] req_wdata,
    input  logic [2:0]        rsp_ack,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              abort_valid,
    output logic [DATA_W-1:0] abort_data
);
    tap_state_e      state_w;
    logic [IR_W-1:0] ir_sr_w;
    logic [IR_W-1:0] ir_w;
    dr_sel_e         dr_sel_w;
    logic            acc_ap_w;
    logic            dr_tdo_w;

    dbg_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state_w)
    );

    dbg_tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .state(state_w), .tdi(tdi),
        .ir_sr(ir_sr_w), .ir(ir_w), .dr_sel(dr_sel_w), .acc_ap(acc_ap_w)
    );

    dbg_tap_dr #(.DATA_W(DATA_W), .IDCODE_VAL(IDCODE_VAL)) u_dr (
        .tck(tck), .trst_n(trst_n), .state(state_w), .dr_sel(dr_sel_w),
        .tdi(tdi), .dr_tdo(dr_tdo_w),
        .req_valid(req_valid), .req_addr(req_addr), .req_rnw(req_rnw),
        .req_wdata(req_wdata), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
        .abort_valid(abort_valid), .abort_data(abort_data)
    );

    assign req_ap = acc_ap_w;

    // Serial output: active only in the two shift states.
    always_comb begin
        unique case (state_w)
            ST_SHIFT_IR: tdo = ir_sr_w[0];
            ST_SHIFT_DR: tdo = dr_tdo_w;
            default:     tdo = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbg_jtag_tap_chk.sv
// Protocol checker for dbg_jtag_tap, attached by bind.
module dbg_jtag_tap_chk
    import dbg_tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir,
    input logic [IR_W-1:0] ir_sr,
    input logic            req_valid,
    input logic            abort_valid
);
    logic [2:0] tms_run;

    // Counts consecutive rising edges with tms high, saturating at 7.
    always_ff @(posedge tck) begin
        if (!trst_n)                tms_run <= '0;
        else if (!tms)              tms_run <= '0;
        else if (tms_run != 3'd7)   tms_run <= tms_run + 3'd1;
    end

    assert_reset_state_R1: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(trst_n) |-> (state == ST_TLR && ir == IR_IDCODE));

    assert_tms_five_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run >= 3'd5) |-> (state == ST_TLR));

    assert_capture_ir_R4: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(state) == ST_CAP_IR) |-> (ir_sr == IR_CAPTURE));

    assert_req_update_R7: assert property (@(posedge tck) disable iff (!trst_n)
        req_valid |-> (state == ST_UPD_DR));

    assert_req_single_R7: assert property (@(posedge tck) disable iff (!trst_n)
        req_valid |=> !req_valid);

    assert_abort_code_R9: assert property (@(posedge tck) disable iff (!trst_n)
        abort_valid |-> (ir == IR_ABORT && !req_valid));
endmodule

bind dbg_jtag_tap dbg_jtag_tap_chk u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state_w), .ir(ir_w),
    .ir_sr(ir_sr_w), .req_valid(req_valid), .abort_valid(abort_valid)
);

// File: tb/tb_dbg_jtag_tap.sv
// Self-checking bench: directed corner cases plus seeded random access scans.
module tb_dbg_jtag_tap;
    localparam int          DW  = 32;
    localparam logic [31:0] IDV = 32'h9C3A_5E71;

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic          tdo;
    logic          req_valid, req_ap, req_rnw, abort_valid;
    logic [1:0]    req_addr;
    logic [DW-1:0] req_wdata, abort_data;
    logic [2:0]    rsp_ack;
    logic [DW-1:0] rsp_rdata;
    logic [2:0]    next_ack = 3'b010;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Captured strobe activity during the last scan.
    int         req_seen, abort_seen;
    logic       lat_ap, lat_rnw;
    logic [1:0] lat_addr;
    logic [31:0] lat_wdata, lat_abort;

    // Expected held response.
    logic [2:0]  exp_ack;
    logic [31:0] exp_rdata;

    always #4 tck = ~tck;

    dbg_jtag_tap #(.DATA_W(DW), .IDCODE_VAL(IDV)) dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .req_valid(req_valid), .req_ap(req_ap), .req_addr(req_addr),
        .req_rnw(req_rnw), .req_wdata(req_wdata), .rsp_ack(rsp_ack),
        .rsp_rdata(rsp_rdata), .abort_valid(abort_valid), .abort_data(abort_data)
    );

    // Bench register-file model.
    function automatic logic [31:0] model_rd(logic ap, logic [1:0] a, logic rnw, logic [31:0] wd);
        if (rnw) return 32'hC0DE_0000 | {24'h0, 4'h0, ap, 1'b0, a};
        return ~wd ^ {29'h0, ap, a};
    endfunction

    always_comb begin
        rsp_ack   = next_ack;
        rsp_rdata = model_rd(req_ap, req_addr, req_rnw, req_wdata);
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck);
        tms = m; tdi = d;
        #1;
        o = tdo;
        if (req_valid) begin
            req_seen++; lat_ap = req_ap; lat_rnw = req_rnw;
            lat_addr = req_addr; lat_wdata = req_wdata;
        end
        if (abort_valid) begin abort_seen++; lat_abort = abort_data; end
        @(posedge tck);
    endtask

    // From Run-Test/Idle, load an instruction; returns the captured bits.
    task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, code[i], o); cap[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    // From Run-Test/Idle, shift n data bits with an optional pause detour.
    task automatic scan_dr(input int n, input logic [34:0] din, input bit pause,
                           output logic [34:0] dout);
        logic o, a, b, c, e;
        req_seen = 0; abort_seen = 0; dout = '0;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < n; i++) begin
            bit brk;
            brk = pause && (i == n/2 - 1);
            step((i == n-1) || brk, din[i], o);
            dout[i] = o;
            if (brk) begin
                step(0, 0, a); step(0, 0, b); step(1, 0, c); step(0, 0, e);
                chk({a, b, c, e} == 4'b0, "R10 tdo idle in exit/pause", {a, b, c, e}, 0);
            end
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    initial begin
        logic [3:0]  cap;
        logic [34:0] dout, din;
        logic        o;
        void'($urandom(32'd7321));
        exp_ack = 3'b010; exp_rdata = '0;

        // R1: reset state
        repeat (3) @(posedge tck);
        @(negedge tck); trst_n = 1'b1; #1;
        chk(tdo == 1'b0 && req_valid == 1'b0 && abort_valid == 1'b0, "R1 reset outputs", {tdo, req_valid, abort_valid}, 0);
        step(0, 0, o);
        scan_dr(32, 35'h0, 0, dout);
        chk(dout[31:0] == IDV, "R1 R6 idcode after reset", dout[31:0], IDV);

        // R4: capture pattern
        scan_ir(4'hE, cap);
        chk(cap == 4'b0001, "R4 capture-ir", cap, 4'b0001);

        // R5: unknown code acts as bypass
        scan_ir(4'h3, cap);
        din = 35'h5B;
        scan_dr(8, din, 0, dout);
        chk(dout[7:0] == {din[6:0], 1'b0}, "R5 bypass code 3", dout[7:0], {din[6:0], 1'b0});
        scan_ir(4'hF, cap);
        din = 35'hA6;
        scan_dr(8, din, 1, dout);
        chk(dout[7:0] == {din[6:0], 1'b0}, "R5 R3 bypass with pause", dout[7:0], {din[6:0], 1'b0});
        chk(req_seen == 0 && abort_seen == 0, "R5 bypass no strobe", req_seen, 0);

        // R8: first access capture is the reset response
        scan_ir(4'hA, cap);
        next_ack = 3'b001;
        din = {32'h1234_5678, 2'b10, 1'b0};
        scan_dr(35, din, 0, dout);
        chk(dout == {32'h0, 3'b010}, "R8 reset response", dout, {32'h0, 3'b010});
        chk(req_seen == 1 && lat_ap == 0 && lat_addr == 2'b10 && lat_rnw == 0 && lat_wdata == 32'h1234_5678,
            "R7 dp write fields", {req_seen[7:0], lat_ap, lat_addr, lat_rnw, lat_wdata}, {8'd1, 4'b0100, 32'h1234_5678});
        exp_ack = 3'b001; exp_rdata = model_rd(0, 2'b10, 0, 32'h1234_5678);

        // R9: abort does not touch the held response
        scan_ir(4'h8, cap);
        din = {32'hDEAD_0001, 3'b111};
        scan_dr(35, din, 0, dout);
        chk(dout == 35'h0, "R9 abort capture", dout, 0);
        chk(abort_seen == 1 && req_seen == 0 && lat_abort == 32'hDEAD_0001, "R9 abort strobe",
            {abort_seen[7:0], req_seen[7:0], lat_abort}, {8'd1, 8'd0, 32'hDEAD_0001});

        // R7 R8: random access scans with some pauses
        for (int k = 0; k < 40; k++) begin
            logic [3:0] code;
            logic       ap;
            ap   = $urandom_range(0, 1);
            code = ap ? 4'hB : 4'hA;
            scan_ir(code, cap);
            din = {$urandom(), 3'($urandom())};
            next_ack = ($urandom_range(0, 3) == 0) ? 3'b001 : (($urandom_range(0, 5) == 0) ? 3'b100 : 3'b010);
            scan_dr(35, din, (k % 5) == 2, dout);
            chk(dout == {exp_rdata, exp_ack}, "R8 posted response", dout, {exp_rdata, exp_ack});
            chk(req_seen == 1 && lat_ap == ap && lat_addr == din[2:1] && lat_rnw == din[0] && lat_wdata == din[34:3],
                "R7 request fields", {req_seen[7:0], lat_ap, lat_addr, lat_rnw, lat_wdata},
                {8'd1, ap, din[2:1], din[0], din[34:3]});
            exp_ack = next_ack; exp_rdata = model_rd(ap, din[2:1], din[0], din[34:3]);
        end

        // R2: random walk then five TMS-high edges reloads the identification code
        scan_ir(4'hF, cap);
        for (int k = 0; k < 9; k++) step(1'($urandom()), 0, o);
        for (int k = 0; k < 5; k++) step(1, 0, o);
        step(0, 0, o);
        scan_dr(32, 35'h0, 0, dout);
        chk(dout[31:0] == IDV, "R2 tms reset reload", dout[31:0], IDV);
        if (req_seen == 0) begin end

        // R1: reset in the middle of a shift
        scan_ir(4'h3, cap);
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        step(0, 1, o); step(0, 1, o);
        @(negedge tck); trst_n = 1'b0; tms = 1'b0;
        @(posedge tck);
        @(negedge tck); trst_n = 1'b1; #1;
        chk(tdo == 1'b0, "R1 R10 tdo after mid-scan reset", tdo, 0);
        step(0, 0, o);
        scan_dr(32, 35'h0, 0, dout);
        chk(dout[31:0] == IDV, "R1 idcode after mid-scan reset", dout[31:0], IDV);

        // R8: reset restores the held response
        scan_ir(4'hB, cap);
        scan_dr(35, 35'h0, 0, dout);
        chk(dout == {32'h0, 3'b010}, "R8 held response reset", dout, {32'h0, 3'b010});

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule